// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects event pulses from many peripheral channels plus one non-maskable line and tells the processor which handler to run next. Each maskable channel has a pending flag, an enable bit and a 4-bit priority, where a smaller value is more urgent. Software programs channels and a global-disable bit through a simple write/read register port. The processor sees a request line and a vector number. It answers with an entry acknowledge and, later, a completion pulse.

Handlers nest. A request is issued only when it is strictly more urgent than the handler now running. The controller keeps a record of the urgency level of every handler in progress. On completion it falls back to the level below and weighs the pending requests again. When a handler completes and another request is already eligible, the controller goes straight into it and keeps its busy indication high. Until entry is acknowledged, the offered vector always follows the most urgent eligible request, so a late arrival replaces an earlier one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_o` and `active_o` are 0, every channel register reads 0 (disabled, priority 0, not pending) and the global control register (address all ones) reads 0.
- R2: A high `src_i[c]` at a clock edge sets the pending flag of channel c. The flag reads back at bit PRIO_W+1 of channel register c and stays set until a write to that register with bit PRIO_W+1 = 1. A source event in the same cycle as a clearing write leaves the flag set.
- R3: Channel register c (address c) holds enable at bit 0 and priority at bits PRIO_W:1. A pending channel whose enable is 0 never drives `irq_o`.
- R4: Among pending, enabled channels the smallest priority value wins. Ties go to the lowest channel number, and `vec_o` carries the winning channel number.
- R5: While a handler is active, `irq_o` rises only for a request strictly more urgent than the active level. A request of equal or lower urgency stays pending and unissued. An acknowledged request becomes the new active level.
- R6: Bit 0 of the global control register blocks all maskable channels from `irq_o`. Pending flags keep accumulating while it is set, and the winner is issued once it is cleared.
- R7: A pulse on `nmi_i` is offered as vector N_CH regardless of global disable and enables, and it outranks every channel. Its own pending state clears on entry, and while it is active nothing else is issued.
- R8: Before `ack_i`, `vec_o` switches to a more urgent request that becomes pending after `irq_o` first rose.
- R9: `done_i` removes the most urgent active level. The controller then re-evaluates the pending requests against the level beneath it.
- R10: When `done_i` ends the last active handler while an eligible request exists, `active_o` stays 1 through that change (tail chaining). Otherwise it falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (channel number, or all ones for global control) |
| wr_data_i | input | PRIO_W+2 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | PRIO_W+2 | Read data, combinational from the read address |
| src_i | input | N_CH | Per-channel event inputs |
| nmi_i | input | 1 | Non-maskable event input |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | $clog2(N_CH+1) | Vector of the offered request |
| ack_i | input | 1 | Handler entry acknowledge |
| done_i | input | 1 | Handler completion |
| active_o | output | 1 | A handler is in progress or being chained into |

## Verification
A handler clears its own pending flag by a register write, and a source can fire in exactly that cycle. The bench provokes this by driving the clearing write and the source pulse on the same edge. It then reads the channel register back, where the flag must still be set. A second collision is an entry acknowledge that happens while a more urgent request is pending at a lower level. The bench nests a preempting handler above a running one, completes them in turn, and judges both the restored level and whether `active_o` stayed high across the final completion.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PRIO_LSB = 1;
  localparam int unsigned GDIS_BIT = 0;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 62,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DATA_W = PRIO_W + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  output logic [DATA_W-1:0]              rd_data_o,
  input  logic [N_CH-1:0]                src_i,
  output logic [N_CH-1:0]                en_o,
  output logic [N_CH-1:0][PRIO_W-1:0]    prio_o,
  output logic [N_CH-1:0]                pend_o,
  output logic                           gdis_o
);
  localparam int unsigned PEND_BIT = PRIO_LSB + PRIO_W;
  localparam logic [ADDR_W-1:0] GCTL_ADDR = '1;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == ADDR_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[c]   <= 1'b0;
        prio_o[c] <= '0;
        pend_o[c] <= 1'b0;
      end else begin
        if (sel) begin
          en_o[c]   <= wr_data_i[EN_BIT];
          prio_o[c] <= wr_data_i[PRIO_LSB +: PRIO_W];
        end
        // new event wins over a clearing write
        if (src_i[c])                      pend_o[c] <= 1'b1;
        else if (sel && wr_data_i[PEND_BIT]) pend_o[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  gdis_o <= 1'b0;
    else if (wr_en_i && wr_addr_i == GCTL_ADDR)   gdis_o <= wr_data_i[GDIS_BIT];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == GCTL_ADDR) rd_data_o[GDIS_BIT] = gdis_o;
    for (int c = 0; c < N_CH; c++) begin
      if (rd_addr_i == ADDR_W'(c)) begin
        rd_data_o[EN_BIT]                = en_o[c];
        rd_data_o[PRIO_LSB +: PRIO_W]    = prio_o[c];
        rd_data_o[PEND_BIT]              = pend_o[c];
      end
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned N_CH   = 62,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned LVL_W = PRIO_W + 1,
  localparam int unsigned VEC_W = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0]              en_i,
  input  logic [N_CH-1:0][PRIO_W-1:0]  prio_i,
  input  logic [N_CH-1:0]              pend_i,
  input  logic                         gdis_i,
  input  logic                         nmi_pend_i,
  output logic                         win_valid_o,
  output logic [VEC_W-1:0]             win_vec_o,
  output logic [LVL_W-1:0]             win_lvl_o
);
  // level 0 is the non-maskable source, channel priority p maps to p+1
  always_comb begin
    win_valid_o = 1'b0;
    win_vec_o   = '0;
    win_lvl_o   = '1;
    if (nmi_pend_i) begin
      win_valid_o = 1'b1;
      win_vec_o   = VEC_W'(N_CH);
      win_lvl_o   = '0;
    end else begin
      // descending scan with <= lets the lowest index win a tie
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (pend_i[c] && en_i[c] && !gdis_i &&
            ({1'b0, prio_i[c]} + LVL_W'(1)) <= win_lvl_o) begin
          win_valid_o = 1'b1;
          win_vec_o   = VEC_W'(c);
          win_lvl_o   = {1'b0, prio_i[c]} + LVL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_lvl.sv
module prio_irq_lvl #(
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned LVL_W = PRIO_W + 1,
  localparam int unsigned NLVL  = (1 << PRIO_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  input  logic             win_valid_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             busy_o,
  output logic             chain_o,
  output logic             nmi_act_o
);
  logic [NLVL-1:0] map_q, map_d, low, rest;
  logic            chain_q;

  assign low  = map_q & (~map_q + NLVL'(1));
  assign rest = map_q & ~low;

  always_comb begin
    cur_lvl_o = '1;
    for (int k = NLVL - 1; k >= 0; k--)
      if (map_q[k]) cur_lvl_o = LVL_W'(k);
  end

  always_comb begin
    map_d = pop_i ? rest : map_q;
    if (push_i) map_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= '0;
      chain_q <= 1'b0;
    end else begin
      map_q <= map_d;
      if (push_i)                                  chain_q <= 1'b0;
      else if (pop_i && rest == '0 && win_valid_i) chain_q <= 1'b1;
      else if (!win_valid_i)                       chain_q <= 1'b0;
    end
  end

  assign busy_o    = |map_q;
  assign chain_o   = chain_q;
  assign nmi_act_o = map_q[0];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_CH   = 62,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DATA_W = PRIO_W + 2,
  localparam int unsigned LVL_W  = PRIO_W + 1,
  localparam int unsigned VEC_W  = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_CH-1:0]   src_i,
  input  logic              nmi_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              ack_i,
  input  logic              done_i,
  output logic              active_o
);
  logic [N_CH-1:0]             en_q, pend_q;
  logic [N_CH-1:0][PRIO_W-1:0] prio_q;
  logic                        gdis_q, nmi_pend_q;
  logic                        win_valid;
  logic [VEC_W-1:0]            win_vec;
  logic [LVL_W-1:0]            win_lvl, cur_lvl;
  logic                        push, pop, busy, chain, nmi_act;

  prio_irq_regs #(.N_CH(N_CH), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .src_i, .en_o(en_q), .prio_o(prio_q), .pend_o(pend_q), .gdis_o(gdis_q)
  );

  prio_irq_arb #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_arb (
    .en_i(en_q), .prio_i(prio_q), .pend_i(pend_q), .gdis_i(gdis_q),
    .nmi_pend_i(nmi_pend_q), .win_valid_o(win_valid), .win_vec_o(win_vec),
    .win_lvl_o(win_lvl)
  );

  prio_irq_lvl #(.PRIO_W(PRIO_W)) u_lvl (
    .clk_i, .rst_ni, .push_i(push), .push_lvl_i(win_lvl), .pop_i(pop),
    .win_valid_i(win_valid), .cur_lvl_o(cur_lvl), .busy_o(busy),
    .chain_o(chain), .nmi_act_o(nmi_act)
  );

  assign irq_o    = win_valid && (win_lvl < cur_lvl);
  assign vec_o    = win_vec;
  assign push     = ack_i && irq_o;
  assign pop      = done_i && busy;
  assign active_o = busy || chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   nmi_pend_q <= 1'b0;
    else if (nmi_i)                                nmi_pend_q <= 1'b1;
    else if (push && win_vec == VEC_W'(N_CH))      nmi_pend_q <= 1'b0;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_CH  = 62,
  parameter int unsigned VEC_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ack_i,
  input logic             active_o,
  input logic [N_CH-1:0]  en_q,
  input logic [N_CH-1:0]  pend_q,
  input logic             gdis_q,
  input logic             nmi_act
);
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_o != VEC_W'(N_CH)) |-> en_q[vec_o]);              // R3
  AST_ISSUE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_o != VEC_W'(N_CH)) |-> pend_q[vec_o]);            // R2
  AST_GDIS_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && gdis_q) |-> vec_o == VEC_W'(N_CH));                   // R6
  AST_NMI_UNPREEMPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_act |-> !irq_o);                                            // R7
  AST_ENTRY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> active_o);                                 // R5
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_CH(N_CH), .VEC_W(VEC_W)) u_chk (
  .clk_i, .rst_ni, .irq_o, .vec_o, .ack_i, .active_o,
  .en_q, .pend_q, .gdis_q, .nmi_act
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 62;
  localparam int PRIO_W = 4;
  localparam int ADDR_W = 8;
  localparam int DW     = PRIO_W + 2;
  localparam int VW     = $clog2(N_CH + 1);
  localparam int CLR    = 1 << (PRIO_W + 1);
  localparam logic [ADDR_W-1:0] GCTL = '1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, nmi = 0, ack = 0, done = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [N_CH-1:0] src = '0;
  logic irq, active;
  logic [VW-1:0] vec;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .src_i(src), .nmi_i(nmi), .irq_o(irq), .vec_o(vec), .ack_i(ack),
    .done_i(done), .active_o(active)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cfg(int en, int pr, int clr);
    return DW'(en) | DW'(pr << 1) | (clr != 0 ? DW'(CLR) : DW'(0));
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output int d);
    rd_addr = a; #1; d = int'(rd_data);
  endtask

  task automatic pulse(int ch);
    @(negedge clk); src[ch] = 1;
    @(negedge clk); src[ch] = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic do_done();
    @(negedge clk); done = 1; @(negedge clk); done = 0;
  endtask

  task automatic t_reset();
    int d;
    check("R1 irq", int'(irq), 0);
    check("R1 active", int'(active), 0);
    rd(8'd5, d);  check("R1 chan reg", d, 0);
    rd(GCTL, d);  check("R1 gctl", d, 0);
  endtask

  task automatic t_pending();
    int d;
    wr(8'd3, cfg(0, 2, 0));
    pulse(3);
    rd(8'd3, d); check("R2 pending set", (d & CLR) != 0 ? 1 : 0, 1);
    check("R3 disabled no irq", int'(irq), 0);
    wr(8'd3, cfg(0, 2, 1));
    rd(8'd3, d); check("R2 cleared", d, int'(cfg(0, 2, 0)));
    @(negedge clk); wr_en = 1; wr_addr = 8'd3; wr_data = cfg(0, 2, 1); src[3] = 1;
    @(negedge clk); wr_en = 0; src[3] = 0;
    rd(8'd3, d); check("R2 event beats clear", (d & CLR) != 0 ? 1 : 0, 1);
    wr(8'd3, cfg(0, 2, 1));
  endtask

  task automatic t_select();
    wr(8'd10, cfg(1, 5, 0));
    wr(8'd20, cfg(1, 3, 0));
    wr(8'd4,  cfg(1, 3, 0));
    @(negedge clk); src[10] = 1; src[20] = 1; src[4] = 1;
    @(negedge clk); src = '0;
    check("R4 irq", int'(irq), 1);
    check("R4 tie lowest index", int'(vec), 4);
    wr(8'd4, cfg(1, 3, 1));
    check("R4 next by prio", int'(vec), 20);
    wr(8'd20, cfg(1, 3, 1));
    check("R4 last", int'(vec), 10);
    wr(8'd10, cfg(1, 5, 1));
    check("R4 none", int'(irq), 0);
  endtask

  task automatic t_nest();
    wr(8'd8,  cfg(1, 6, 0));
    wr(8'd9,  cfg(1, 2, 0));
    wr(8'd11, cfg(1, 6, 0));
    pulse(8);
    check("R5 first vec", int'(vec), 8);
    do_ack();
    check("R5 active", int'(active), 1);
    check("R5 same level silent", int'(irq), 0);
    pulse(11);
    check("R5 equal prio held", int'(irq), 0);
    pulse(9);
    check("R5 preempt irq", int'(irq), 1);
    check("R5 preempt vec", int'(vec), 9);
    do_ack();
    wr(8'd9, cfg(1, 2, 1));
    do_done();
    check("R9 back at level 6", int'(irq), 0);
    check("R9 still active", int'(active), 1);
    wr(8'd8, cfg(1, 6, 1));
    do_done();
    check("R10 chain active", int'(active), 1);
    check("R9 re-eval irq", int'(irq), 1);
    check("R9 re-eval vec", int'(vec), 11);
    do_ack();
    wr(8'd11, cfg(1, 6, 1));
    do_done();
    check("R10 return to idle", int'(active), 0);
    check("R9 idle irq", int'(irq), 0);
  endtask

  task automatic t_gdis();
    int d;
    wr(GCTL, DW'(1));
    wr(8'd12, cfg(1, 1, 0));
    pulse(12);
    check("R6 blocked", int'(irq), 0);
    rd(8'd12, d); check("R6 pending kept", (d & CLR) != 0 ? 1 : 0, 1);
    wr(GCTL, DW'(0));
    check("R6 released irq", int'(irq), 1);
    check("R6 released vec", int'(vec), 12);
    wr(8'd12, cfg(1, 1, 1));
  endtask

  task automatic t_nmi();
    wr(GCTL, DW'(1));
    wr(8'd0, cfg(1, 0, 0));
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    check("R7 nmi irq", int'(irq), 1);
    check("R7 nmi vec", int'(vec), N_CH);
    do_ack();
    wr(GCTL, DW'(0));
    pulse(0);
    check("R7 not preempted", int'(irq), 0);
    do_done();
    check("R7 nmi pend cleared", int'(vec), 0);
    check("R7 ch0 irq", int'(irq), 1);
    do_ack();
    wr(8'd0, cfg(1, 0, 1));
    do_done();
    check("R7 idle", int'(active), 0);
  endtask

  task automatic t_late();
    wr(8'd30, cfg(1, 7, 0));
    wr(8'd31, cfg(1, 1, 0));
    pulse(30);
    check("R8 first", int'(vec), 30);
    pulse(31);
    check("R8 replaced", int'(vec), 31);
    do_ack();
    check("R8 entered urgent", int'(irq), 0);
    wr(8'd31, cfg(1, 1, 1));
    wr(8'd30, cfg(1, 7, 1));
    do_done();
    check("R8 idle", int'(active), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_select();
        t_nest();
        t_gdis();
        t_nmi();
        t_late();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule